// File: doc/BRIEF.md
# Emulation Trap Frame Writer

This block sits in the exception path of a processor that implements only part of its instruction set. When the decoder meets an opcode that the hardware cannot execute, it hands this block one request. The request carries the opcode, the address of the faulting instruction, up to eight operand values that have already been evaluated, the address of the following instruction, the status longword, the current stack pointer and a flag that says whether the instruction was interrupted part-way and is now being resumed. The block writes an exception frame onto the downward-growing stack, one 32-bit word per memory transaction. It then reports the new stack pointer and which of two emulation vectors the core should dispatch through, so that control goes directly to the software emulator.

Two frame shapes exist. A fresh instruction gets a full frame. From the lowest address up, the full frame holds the opcode, the instruction address, the operands from first to last, the next-instruction address and the status word. A resumed instruction (resume flag set) is not parsed again. It gets a two-word frame: the original instruction address, with the status word above it. Both frames are written top-down, so the status word always lands first, just below the incoming stack pointer.

The request side is a valid/ready stream. `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and all request fields are captured at that edge. The memory side is also valid/ready. The block holds `mem_valid`, `mem_addr` and `mem_data` steady until the memory accepts the word with `mem_ready`. The memory reports a failed write by raising `mem_err` in the same cycle as `mem_ready`.

Top module: `emu_frame_gen`

## Requirements
- R1: After reset, `busy`, `mem_valid`, `done` and `err` are 0, `req_ready` is 1, and `sp_new` and `vec_sel` are 0.
- R2: A request is accepted only when `req_ready` is high, and `req_ready` is low for the whole frame write. While the block is busy, `req_valid` and the request fields have no effect on the frame being written or on any later write.
- R3: With `req_fpd`=0, the writes go out in this order: status word at SP-4, next-instruction address at SP-8, operands from last to first, instruction address, and finally the opcode at the lowest address. The opcode is zero-extended into the low bits of its word. Each write sits 4 bytes below the one before.
- R4: The operand count selects the full frame size: 4+count words for counts 0 to 8. Any count above 8 is treated as 8. Operand k (counting from 0) is taken from bits [32k+31:32k] of `req_opnds`.
- R5: With `req_fpd`=1, exactly two words are written: the status word at SP-4, then the instruction address at SP-8. The opcode, the operands and the next-instruction address are not written.
- R6: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R7: In the cycle after the final write is accepted without error, `done` is high for exactly one cycle. In that same cycle `sp_new` becomes SP-4×(frame words) and `vec_sel` becomes 0 for a full frame or 1 for a resume frame. `sp_new` changes at no other time.
- R8: If a write is accepted with `mem_err` high, no further write is issued. `err` is high for exactly one cycle, in the next cycle. `done` does not rise for that request, and `sp_new` and `vec_sel` keep their earlier values.
- R9: `busy` is high from the cycle after acceptance until the final write, or the failed write, is accepted. It is low in the cycle where `done` or `err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready (idle) |
| req_opcode | input | 16 | Unimplemented opcode |
| req_pc | input | 32 | Address of the faulting instruction |
| req_count | input | 4 | Number of decoded operands (0 to 8) |
| req_opnds | input | 256 | Decoded operands, operand k in bits [32k+31:32k] |
| req_next_pc | input | 32 | Address of the next instruction |
| req_psl | input | 32 | Processor status longword |
| req_sp | input | 32 | Stack pointer before the frame |
| req_fpd | input | 1 | Resume flag: 1 selects the two-word frame |
| busy | output | 1 | Frame write in progress |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 32 | Word to write |
| mem_err | input | 1 | Write failed, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse |
| sp_new | output | 32 | Stack pointer after the last completed frame |
| vec_sel | output | 1 | Vector index: 0 full frame, 1 resume frame |

## Verification
A wrong word index or a wrong length latch shows up at the memory port within one write. It appears as a wrong word at a given address, or as a count of writes that is off by one or more. A wrong address step appears on the second write. Each directed scenario therefore compares every accepted write, in order, against a frame built from the requirements, and then confirms that no further write follows. A failure to stop after an error, or a stray completion, shows in the cycle after the failing write as a `mem_valid` that stays high, a missing `err` pulse or a changed `sp_new`.

// File: rtl/emu_frame_pkg.sv
package emu_frame_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } fw_state_t;

  localparam int unsigned VEC_FULL   = 0;
  localparam int unsigned VEC_RESUME = 1;
endpackage

// File: rtl/emu_frame_ctl.sv
module emu_frame_ctl
  import emu_frame_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             mem_ready,
  input  logic             mem_err,
  output logic             req_ready,
  output logic             accept,
  output logic             busy,
  output logic             mem_valid,
  output logic             step,
  output logic             fin,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             err
);
  fw_state_t        st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q, err_q;
  logic             hs, hs_bad;

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q == ST_WRITE);
  assign mem_valid = busy;
  assign accept    = req_ready && req_valid;
  assign hs        = busy && mem_ready;
  assign hs_bad    = hs && mem_err;
  assign step      = hs && !mem_err && (idx_q != '0);
  assign fin       = hs && !mem_err && (idx_q == '0);
  assign idx       = idx_q;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= fin;
      err_q  <= hs_bad;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q  <= ST_WRITE;
            idx_q <= last_idx;
          end
        end
        ST_WRITE: begin
          if (hs_bad || fin) begin
            st_q <= ST_IDLE;
          end else if (step) begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/emu_frame_addr.sv
module emu_frame_addr #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] sp_in,
  output logic [DATA_W-1:0] addr
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] STRIDE = DATA_W'(WORD_BYTES);

  logic [DATA_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= sp_in - STRIDE;
    end else if (step) begin
      addr_q <= addr_q - STRIDE;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/emu_frame_mux.sv
module emu_frame_mux #(
  parameter int DATA_W   = 32,
  parameter int OPC_W    = 16,
  parameter int MAX_OPND = 8,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 4
) (
  input  logic                       fpd,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [IDX_W-1:0]           idx,
  input  logic [OPC_W-1:0]           opcode,
  input  logic [DATA_W-1:0]          pc,
  input  logic [MAX_OPND*DATA_W-1:0] opnds,
  input  logic [DATA_W-1:0]          next_pc,
  input  logic [DATA_W-1:0]          psl,
  output logic [DATA_W-1:0]          word
);
  logic [DATA_W-1:0] opnd_arr [MAX_OPND];
  logic [IDX_W-1:0]  npc_idx;

  for (genvar g = 0; g < MAX_OPND; g++) begin : g_unpack
    assign opnd_arr[g] = opnds[g*DATA_W +: DATA_W];
  end

  assign npc_idx = IDX_W'(cnt) + IDX_W'(2);

  always_comb begin
    word = psl;
    if (fpd) begin
      word = (idx == '0) ? pc : psl;
    end else if (idx == '0) begin
      word = DATA_W'(opcode);
    end else if (idx == IDX_W'(1)) begin
      word = pc;
    end else if (idx == npc_idx) begin
      word = next_pc;
    end else if (idx > npc_idx) begin
      word = psl;
    end else begin
      for (int k = 0; k < MAX_OPND; k++) begin
        if (idx == IDX_W'(k + 2)) word = opnd_arr[k];
      end
    end
  end
endmodule

// File: rtl/emu_frame_gen.sv
module emu_frame_gen
  import emu_frame_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int OPC_W    = 16,
  parameter int MAX_OPND = 8,
  parameter int CNT_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [OPC_W-1:0]           req_opcode,
  input  logic [DATA_W-1:0]          req_pc,
  input  logic [CNT_W-1:0]           req_count,
  input  logic [MAX_OPND*DATA_W-1:0] req_opnds,
  input  logic [DATA_W-1:0]          req_next_pc,
  input  logic [DATA_W-1:0]          req_psl,
  input  logic [DATA_W-1:0]          req_sp,
  input  logic                       req_fpd,
  output logic                       busy,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic [DATA_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_data,
  input  logic                       mem_err,
  output logic                       done,
  output logic                       err,
  output logic [DATA_W-1:0]          sp_new,
  output logic                       vec_sel
);
  localparam int IDX_W = $clog2(MAX_OPND + 4);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OPND);

  logic [CNT_W-1:0]           cnt_c, cnt_q;
  logic [IDX_W-1:0]           last_idx, idx;
  logic                       accept, step, fin;
  logic [OPC_W-1:0]           opc_q;
  logic [DATA_W-1:0]          pc_q, npc_q, psl_q, sp_q;
  logic [MAX_OPND*DATA_W-1:0] opnd_q;
  logic                       fpd_q, vec_q;

  // counts above the operand limit are clamped (R4)
  assign cnt_c    = (req_count > CNT_MAX) ? CNT_MAX : req_count;
  assign last_idx = req_fpd ? IDX_W'(1) : (IDX_W'(cnt_c) + IDX_W'(3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      pc_q   <= '0;
      npc_q  <= '0;
      psl_q  <= '0;
      opnd_q <= '0;
      cnt_q  <= '0;
      fpd_q  <= 1'b0;
    end else if (accept) begin
      opc_q  <= req_opcode;
      pc_q   <= req_pc;
      npc_q  <= req_next_pc;
      psl_q  <= req_psl;
      opnd_q <= req_opnds;
      cnt_q  <= cnt_c;
      fpd_q  <= req_fpd;
    end
  end

  // result registers move only on a clean finish (R7, R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      vec_q <= 1'b0;
    end else if (fin) begin
      sp_q  <= mem_addr;
      vec_q <= fpd_q ? 1'(VEC_RESUME) : 1'(VEC_FULL);
    end
  end

  assign sp_new  = sp_q;
  assign vec_sel = vec_q;

  emu_frame_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .last_idx  (last_idx),
    .mem_ready (mem_ready),
    .mem_err   (mem_err),
    .req_ready (req_ready),
    .accept    (accept),
    .busy      (busy),
    .mem_valid (mem_valid),
    .step      (step),
    .fin       (fin),
    .idx       (idx),
    .done      (done),
    .err       (err)
  );

  emu_frame_addr #(.DATA_W(DATA_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (step),
    .sp_in (req_sp),
    .addr  (mem_addr)
  );

  emu_frame_mux #(
    .DATA_W   (DATA_W),
    .OPC_W    (OPC_W),
    .MAX_OPND (MAX_OPND),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_mux (
    .fpd     (fpd_q),
    .cnt     (cnt_q),
    .idx     (idx),
    .opcode  (opc_q),
    .pc      (pc_q),
    .opnds   (opnd_q),
    .next_pc (npc_q),
    .psl     (psl_q),
    .word    (mem_data)
  );
endmodule

// File: rtl/emu_frame_chk.sv
module emu_frame_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_err,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] sp_new
);
  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_sp_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sp_new));

  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err) |=> (err && !mem_valid && !done));

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_idle_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);
endmodule

bind emu_frame_gen emu_frame_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_err   (mem_err),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .done      (done),
  .err       (err),
  .sp_new    (sp_new)
);

// File: tb/sim_emu_frame_gen.sv
module sim_emu_frame_gen;
  logic         clk, rst_n;
  logic         req_valid, req_ready;
  logic [15:0]  req_opcode;
  logic [31:0]  req_pc, req_next_pc, req_psl, req_sp;
  logic [3:0]   req_count;
  logic [255:0] req_opnds;
  logic         req_fpd, busy;
  logic         mem_valid, mem_ready, mem_err;
  logic [31:0]  mem_addr, mem_data, sp_new;
  logic         done, err, vec_sel;

  int nchk = 0, nerr = 0;
  int nwr = 0, stall_cfg = 0, err_at = -1, waitc = 0;
  logic [31:0] addr_log [0:31];
  logic [31:0] data_log [0:31];

  emu_frame_gen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_pc(req_pc), .req_count(req_count),
    .req_opnds(req_opnds), .req_next_pc(req_next_pc), .req_psl(req_psl),
    .req_sp(req_sp), .req_fpd(req_fpd), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_err(mem_err), .done(done), .err(err), .sp_new(sp_new), .vec_sel(vec_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory responder: decides at each falling edge, handshake on next rising edge
  initial begin
    mem_ready = 1'b0;
    mem_err   = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_valid) begin
        if (waitc < stall_cfg) begin
          waitc++;
          mem_ready = 1'b0;
          mem_err   = 1'b0;
        end else begin
          waitc = 0;
          mem_ready = 1'b1;
          if (nwr < 32) begin
            addr_log[nwr] = mem_addr;
            data_log[nwr] = mem_data;
          end
          mem_err = (nwr == err_at);
          nwr++;
        end
      end else begin
        waitc = 0;
        mem_ready = 1'b0;
        mem_err   = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not end act=%0d exp=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] item_word(input int i, input bit fpd, input int nop);
    if (fpd) return (i == 0) ? req_pc : req_psl;
    if (i == 0) return {16'h0000, req_opcode};
    if (i == 1) return req_pc;
    if (i < nop + 2) return req_opnds[(i-2)*32 +: 32];
    if (i == nop + 2) return req_next_pc;
    return req_psl;
  endfunction

  task automatic set_fields(input int tid, input bit fpd, input int cnt, input logic [31:0] sp);
    req_opcode  = 16'hFD00 + 16'(tid);
    req_pc      = 32'h0001_0000 + 32'(tid * 256);
    req_next_pc = req_pc + 32'd9;
    req_psl     = 32'h0400_0000 + 32'(tid);
    req_sp      = sp;
    req_fpd     = fpd;
    req_count   = 4'(cnt);
    for (int k = 0; k < 8; k++) req_opnds[k*32 +: 32] = 32'hC0DE_0000 + 32'(tid * 16 + k);
  endtask

  // one scenario: issue, optionally poke the request port while busy, check the frame
  task automatic run_frame(input string tag, input int tid, input bit fpd, input int cnt,
                           input logic [31:0] sp, input int stall, input int errat,
                           input bit poke);
    int n, nop, expw, cyc;
    bit got_done, got_err, busy_at_end, done_after, err_after;
    logic [31:0] prev_sp;
    logic prev_vec;
    logic [31:0] s_opc, s_sp;
    bit s_fpd;
    prev_sp = sp_new; prev_vec = vec_sel;
    nwr = 0; stall_cfg = stall; err_at = errat; waitc = 0;
    set_fields(tid, fpd, cnt, sp);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      s_opc = 32'(req_opcode); s_sp = req_sp; s_fpd = req_fpd;
      req_opcode = 16'h1234; req_sp = sp + 32'h40; req_fpd = ~fpd;
      for (int c = 0; c < 3; c++) begin
        req_valid = 1'b1;
        check(req_ready == 1'b0, "R2", {tag, " req_ready while busy"}, 32'(req_ready), 0);
        check(busy == 1'b1, "R9", {tag, " busy during frame"}, 32'(busy), 1);
        @(negedge clk);
      end
      req_valid = 1'b0;
      req_opcode = s_opc[15:0]; req_sp = s_sp; req_fpd = s_fpd;
    end
    cyc = 0;
    while (!done && !err && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    got_done = done; got_err = err; busy_at_end = busy;
    @(negedge clk);
    done_after = done; err_after = err;
    repeat (3) @(negedge clk);
    nop  = (cnt > 8) ? 8 : cnt;
    n    = fpd ? 2 : 4 + nop;
    expw = (errat >= 0) ? errat + 1 : n;
    check(nwr == expw, fpd ? "R5" : "R4", {tag, " write count"}, 32'(nwr), 32'(expw));
    for (int j = 0; j < expw && j < nwr; j++) begin
      check(addr_log[j] == sp - 32'(4 * (j + 1)), "R3", {tag, " write address"},
            addr_log[j], sp - 32'(4 * (j + 1)));
      check(data_log[j] == item_word(n - 1 - j, fpd, nop), fpd ? "R5" : "R3",
            {tag, " write data"}, data_log[j], item_word(n - 1 - j, fpd, nop));
    end
    check(busy_at_end == 1'b0, "R9", {tag, " busy low at end"}, 32'(busy_at_end), 0);
    if (errat < 0) begin
      check(got_done && !got_err, "R7", {tag, " done seen"}, 32'({got_err, got_done}), 32'h1);
      check(!done_after, "R7", {tag, " done one cycle"}, 32'(done_after), 0);
      check(sp_new == sp - 32'(4 * n), "R7", {tag, " new SP"}, sp_new, sp - 32'(4 * n));
      check(vec_sel == fpd, "R7", {tag, " vector index"}, 32'(vec_sel), 32'(fpd));
    end else begin
      check(got_err && !got_done, "R8", {tag, " err seen"}, 32'({got_err, got_done}), 32'h2);
      check(!err_after, "R8", {tag, " err one cycle"}, 32'(err_after), 0);
      check(sp_new == prev_sp, "R8", {tag, " SP kept"}, sp_new, prev_sp);
      check(vec_sel == prev_vec, "R8", {tag, " vector kept"}, 32'(vec_sel), 32'(prev_vec));
    end
    err_at = -1;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_valid && !done && !err, "R1", "reset outputs low",
          32'({busy, mem_valid, done, err}), 0);
    check(req_ready == 1'b1, "R1", "reset req_ready", 32'(req_ready), 1);
    check(sp_new == 0 && vec_sel == 0, "R1", "reset SP and vector", sp_new, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    req_valid = 1'b0;
    set_fields(0, 1'b0, 0, 32'h0);
    test_reset();
    run_frame("full0",   1, 1'b0, 0,  32'h0000_8000, 0, -1, 1'b0);
    run_frame("full3",   2, 1'b0, 3,  32'h0000_7F00, 2, -1, 1'b0);
    run_frame("full8",   3, 1'b0, 8,  32'h0000_9000, 0, -1, 1'b0);
    run_frame("clamp13", 4, 1'b0, 13, 32'h0000_A000, 1, -1, 1'b0);
    run_frame("resume",  5, 1'b1, 6,  32'h0000_B000, 1, -1, 1'b0);
    run_frame("abort",   6, 1'b0, 2,  32'h0000_C000, 0, 2,  1'b0);
    run_frame("abort1st",7, 1'b1, 0,  32'h0000_C100, 3, 0,  1'b0);
    run_frame("pokebusy",8, 1'b0, 5,  32'h0000_D000, 1, -1, 1'b1);
    run_frame("after",   9, 1'b1, 0,  32'h0000_E000, 0, -1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule